// File: doc/BRIEF.md
# Cache Maintenance Clean/Invalidate Engine

This block holds the valid, dirty and tag state of a set-associative cache. It carries out the maintenance commands that software issues against that state. A command has three parts: an opcode (invalidate, clean, clean-and-invalidate or test-clean), a scope and an operand. The scope is one of three:
- the whole cache;
- the line that holds a given address;
- an explicit set and way.

Dirty lines are written back over a ready/valid write-back port, one line address per transfer. The data path is outside the block.

Processor-side line installs arrive on an install port. A tag lookup port gives the cache its hit and dirty answer. While a command runs the engine raises `busy` and the install port refuses new lines. Each command ends with a one-cycle `done` pulse. During that pulse `done_more` shows whether any dirty line is left. Software repeats test-clean until that flag drops.

A whole-cache walk visits one line per cycle. The set index is the inner loop and the way index the outer loop, so line index = way * SETS + set. Invalidate of the whole cache clears all state in a single cycle in the default variant.

Top module: `cme_engine`

## Requirements
- R1: Clean writes a dirty line back once, clears its dirty bit and leaves it valid, so a later lookup still hits with dirty low.
- R2: Invalidate clears the valid bit of every line in its scope and issues no write-back, even for dirty lines. A whole-cache invalidate completes with `done` in the cycle after acceptance.
- R3: Clean-and-invalidate writes back each dirty line in its scope and then marks it invalid. Clean lines in scope are invalidated without traffic.
- R4: Scope codes are 0 = whole cache, 1 = line holding address, 2 = set/way. For code 2, the set is operand bits [OFF_W+SET_W-1:OFF_W] (bits 7:5 by default) and the way is the top WAY_W operand bits (31:30). Scope 3 completes with no state change and no traffic. Opcode codes are 0 = invalidate, 1 = clean, 2 = clean-and-invalidate, 3 = test-clean.
- R5: A whole-cache walk issues write-backs in increasing set order within a way, then moves to the next way.
- R6: Test-clean ignores the scope and writes back only the first dirty line in walk order. If no line is dirty it completes with no traffic.
- R7: Address-scoped commands and lookups ignore the low OFF_W (5) address bits.
- R8: An address-scoped command whose address misses completes with no write-back and no state change.
- R9: While `busy` is high, `ins_ready` is low and no command is accepted. `busy` falls in the cycle after `done`.
- R10: A write-back request holds `wb_valid` and a stable `wb_addr` until `wb_ready`. The address is {tag, set, OFF_W zero bits}.
- R11: After reset no line is valid or dirty, and `busy`, `done` and `wb_valid` are low.
- R12: During `done`, `done_more` is high exactly when at least one dirty line remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | Opcode |
| cmd_scope | input | 2 | Scope code |
| cmd_operand | input | ADDR_W | Address or set/way operand |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_more | output | 1 | Dirty lines remain (valid with done) |
| ins_valid | input | 1 | Install a line |
| ins_ready | output | 1 | Install accepted this cycle |
| ins_addr | input | ADDR_W | Address of the installed line |
| ins_way | input | WAY_W | Way to place it in |
| ins_dirty | input | 1 | Install as dirty |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup hits a valid line |
| lk_dirty | output | 1 | Hit line is dirty |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Memory takes the write-back |
| wb_addr | output | ADDR_W | Line-aligned write-back address |

## Verification
The hardest state to reach from the ports is a write-back held off by memory partway through a whole-cache clean-and-invalidate. At that point the engine is busy, installs are refused and the request must stay frozen. The bench first installs a dirty line in a late set and holds `wb_ready` low. It then starts the walk and samples the stalled request over several cycles before releasing it. Walk order is exposed by scattering dirty lines across sets and ways, so that set-first and way-first orders would emit different address sequences.

// File: rtl/cme_pkg.sv
package cme_pkg;

   typedef enum logic [1:0] {
      OP_INV   = 2'd0,
      OP_CLEAN = 2'd1,
      OP_CLINV = 2'd2,
      OP_TEST  = 2'd3
   } cme_op_e;

   typedef enum logic [1:0] {
      SC_ALL    = 2'd0,
      SC_ADDR   = 2'd1,
      SC_SETWAY = 2'd2,
      SC_RSVD   = 2'd3
   } cme_scope_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LINE = 2'd1,
      ST_WB   = 2'd2,
      ST_DONE = 2'd3
   } cme_state_e;

endpackage

// File: rtl/cme_tag_store.sv
module cme_tag_store #(
   parameter int N     = 32,
   parameter int TAG_W = 24,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_clr_valid,
   input  logic             upd_clr_dirty,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic [TAG_W-1:0] ins_tag,
   input  logic             ins_dirty,
   output logic [N-1:0]     valid_o,
   output logic [N-1:0]     dirty_o,
   output logic [TAG_W-1:0] tag_o [N]
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= '0;
         dirty_o <= '0;
         for (int i = 0; i < N; i++) tag_o[i] <= '0;
      end else if (clr_all) begin
         valid_o <= '0;
         dirty_o <= '0;
      end else if (upd_en) begin
         if (upd_clr_valid) valid_o[upd_idx] <= 1'b0;
         if (upd_clr_dirty) dirty_o[upd_idx] <= 1'b0;
      end else if (ins_en) begin
         valid_o[ins_idx] <= 1'b1;
         dirty_o[ins_idx] <= ins_dirty;
         tag_o[ins_idx]   <= ins_tag;
      end
   end

endmodule

// File: rtl/cme_way_match.sv
module cme_way_match #(
   parameter int SETS  = 8,
   parameter int WAYS  = 4,
   parameter int TAG_W = 24,
   parameter int SET_W = 3,
   parameter int WAY_W = 2
) (
   input  logic [SETS*WAYS-1:0] valid_i,
   input  logic [TAG_W-1:0]     tag_i [SETS*WAYS],
   input  logic [SET_W-1:0]     set_i,
   input  logic [TAG_W-1:0]     tag_cmp,
   output logic                 hit_o,
   output logic [WAY_W-1:0]     way_o
);

   always_comb begin
      hit_o = 1'b0;
      way_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (valid_i[w*SETS + int'(set_i)] &&
             tag_i[w*SETS + int'(set_i)] == tag_cmp) begin
            hit_o = 1'b1;
            way_o = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/cme_first_dirty.sv
module cme_first_dirty #(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input  logic [N-1:0]     dirty_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (dirty_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/cme_engine.sv
module cme_engine
   import cme_pkg::*;
#(
   parameter int  ADDR_W    = 32,
   parameter int  OFF_W     = 5,
   parameter int  SETS      = 8,
   parameter int  WAYS      = 4,
   parameter bit  FAST_INV  = 1'b1,
   localparam int SET_W     = $clog2(SETS),
   localparam int WAY_W     = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [1:0]        cmd_scope,
   input  logic [ADDR_W-1:0] cmd_operand,
   output logic              busy,
   output logic              done,
   output logic              done_more,
   input  logic              ins_valid,
   output logic              ins_ready,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [WAY_W-1:0]  ins_way,
   input  logic              ins_dirty,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic              lk_dirty,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr
);

   localparam int IDX_W = SET_W + WAY_W;
   localparam int N     = SETS * WAYS;
   localparam int TAG_W = ADDR_W - OFF_W - SET_W;
   localparam int TAG_LO = OFF_W + SET_W;

   if ((1 << SET_W) != SETS || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if ((1 << WAY_W) != WAYS || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1 || WAY_W > ADDR_W - TAG_LO + TAG_W) begin : g_bad_addr
      $error("address too narrow for the chosen geometry");
   end

   cme_state_e             state_q;
   cme_op_e                op_q;
   logic [IDX_W-1:0]       idx_q;
   logic                   single_q;

   logic [N-1:0]           valid_v;
   logic [N-1:0]           dirty_v;
   logic [TAG_W-1:0]       tag_v [N];

   logic                   clr_all;
   logic                   upd_en;
   logic                   upd_clr_valid;
   logic                   upd_clr_dirty;
   logic                   ins_en;

   logic                   cmd_fire;
   logic                   cmd_hit;
   logic [WAY_W-1:0]       cmd_way;
   logic                   fd_found;
   logic [IDX_W-1:0]       fd_idx;
   logic [WAY_W-1:0]       lk_way;
   logic                   fast_inv;

   // variant select for whole-cache invalidate
   if (FAST_INV) begin : g_inv_flat
      assign fast_inv = 1'b1;
   end else begin : g_inv_walk
      assign fast_inv = 1'b0;
   end

   // field extraction
   logic [SET_W-1:0] cmd_set;
   logic [TAG_W-1:0] cmd_tag;
   logic [SET_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   logic [IDX_W-1:0] sw_idx;
   logic [IDX_W-1:0] ins_idx;

   assign cmd_set = cmd_operand[OFF_W +: SET_W];
   assign cmd_tag = cmd_operand[ADDR_W-1:TAG_LO];
   assign lk_set  = lk_addr[OFF_W +: SET_W];
   assign lk_tag  = lk_addr[ADDR_W-1:TAG_LO];
   assign sw_idx  = {cmd_operand[ADDR_W-1 -: WAY_W], cmd_set};
   assign ins_idx = {ins_way, ins_addr[OFF_W +: SET_W]};

   cme_tag_store #(
      .N     (N),
      .TAG_W (TAG_W),
      .IDX_W (IDX_W)
   ) u_store (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr_all       (clr_all),
      .upd_en        (upd_en),
      .upd_idx       (idx_q),
      .upd_clr_valid (upd_clr_valid),
      .upd_clr_dirty (upd_clr_dirty),
      .ins_en        (ins_en),
      .ins_idx       (ins_idx),
      .ins_tag       (ins_addr[ADDR_W-1:TAG_LO]),
      .ins_dirty     (ins_dirty),
      .valid_o       (valid_v),
      .dirty_o       (dirty_v),
      .tag_o         (tag_v)
   );

   cme_way_match #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .SET_W (SET_W),
      .WAY_W (WAY_W)
   ) u_cmd_match (
      .valid_i (valid_v),
      .tag_i   (tag_v),
      .set_i   (cmd_set),
      .tag_cmp (cmd_tag),
      .hit_o   (cmd_hit),
      .way_o   (cmd_way)
   );

   cme_way_match #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .SET_W (SET_W),
      .WAY_W (WAY_W)
   ) u_lk_match (
      .valid_i (valid_v),
      .tag_i   (tag_v),
      .set_i   (lk_set),
      .tag_cmp (lk_tag),
      .hit_o   (lk_hit),
      .way_o   (lk_way)
   );

   cme_first_dirty #(
      .N     (N),
      .IDX_W (IDX_W)
   ) u_first (
      .dirty_i (dirty_v),
      .found_o (fd_found),
      .idx_o   (fd_idx)
   );

   assign lk_dirty  = lk_hit && dirty_v[{lk_way, lk_set}];
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign done_more = |dirty_v;
   assign ins_ready = (state_q == ST_IDLE) && !cmd_valid;
   assign ins_en    = ins_valid && ins_ready;
   assign cmd_fire  = cmd_valid && (state_q == ST_IDLE);
   assign wb_valid  = (state_q == ST_WB);
   assign wb_addr   = {tag_v[idx_q], idx_q[SET_W-1:0], {OFF_W{1'b0}}};

   logic line_dirty;
   logic line_last;
   assign line_dirty = valid_v[idx_q] && dirty_v[idx_q];
   assign line_last  = single_q || (idx_q == IDX_W'(N - 1));

   // store update requests
   always_comb begin
      clr_all       = 1'b0;
      upd_en        = 1'b0;
      upd_clr_valid = 1'b0;
      upd_clr_dirty = 1'b0;
      if (cmd_fire && cme_op_e'(cmd_op) == OP_INV &&
          cme_scope_e'(cmd_scope) == SC_ALL && fast_inv) begin
         clr_all = 1'b1;
      end
      if (state_q == ST_LINE && !(op_q != OP_INV && line_dirty)) begin
         upd_en        = 1'b1;
         upd_clr_valid = (op_q != OP_CLEAN);
         upd_clr_dirty = (op_q != OP_CLEAN);
      end
      if (state_q == ST_WB && wb_ready) begin
         upd_en        = 1'b1;
         upd_clr_valid = (op_q == OP_CLINV);
         upd_clr_dirty = 1'b1;
      end
   end

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= OP_INV;
         idx_q    <= '0;
         single_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_fire) begin
                  op_q     <= cme_op_e'(cmd_op);
                  single_q <= 1'b1;
                  if (cme_op_e'(cmd_op) == OP_TEST) begin
                     op_q    <= OP_CLEAN;
                     idx_q   <= fd_idx;
                     state_q <= fd_found ? ST_LINE : ST_DONE;
                  end else begin
                     unique case (cme_scope_e'(cmd_scope))
                        SC_ALL: begin
                           idx_q    <= '0;
                           single_q <= 1'b0;
                           if (cme_op_e'(cmd_op) == OP_INV && fast_inv)
                              state_q <= ST_DONE;
                           else
                              state_q <= ST_LINE;
                        end
                        SC_ADDR: begin
                           idx_q   <= {cmd_way, cmd_set};
                           state_q <= cmd_hit ? ST_LINE : ST_DONE;
                        end
                        SC_SETWAY: begin
                           idx_q   <= sw_idx;
                           state_q <= ST_LINE;
                        end
                        default: state_q <= ST_DONE;
                     endcase
                  end
               end
            end
            ST_LINE: begin
               if (op_q != OP_INV && line_dirty) begin
                  state_q <= ST_WB;
               end else if (line_last) begin
                  state_q <= ST_DONE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_WB: begin
               if (wb_ready) begin
                  if (line_last) begin
                     state_q <= ST_DONE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_LINE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cme_engine_chk.sv
module cme_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int N      = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ins_ready,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [ADDR_W-1:0] wb_addr,
   input logic [N-1:0]      valid_vec,
   input logic [N-1:0]      dirty_vec,
   input logic [1:0]        op_q
);

   // R10
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

   // R10
   wb_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> busy);

   // R9
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ins_ready);

   // R9
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R2
   inv_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == 2'd0) |-> !wb_valid);

   // R3
   dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dirty_vec & ~valid_vec) == '0));

endmodule

bind cme_engine cme_engine_chk #(
   .ADDR_W (ADDR_W),
   .N      (N)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .ins_ready (ins_ready),
   .wb_valid  (wb_valid),
   .wb_ready  (wb_ready),
   .wb_addr   (wb_addr),
   .valid_vec (valid_v),
   .dirty_vec (dirty_v),
   .op_q      (op_q)
);

// File: tb/cme_engine_bench.sv
module cme_engine_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [1:0]  cmd_scope = '0;
   logic [31:0] cmd_operand = '0;
   logic        busy, done, done_more;
   logic        ins_valid = 1'b0;
   logic        ins_ready;
   logic [31:0] ins_addr = '0;
   logic [1:0]  ins_way = '0;
   logic        ins_dirty = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_hit, lk_dirty;
   logic        wb_valid;
   logic        wb_ready = 1'b1;
   logic [31:0] wb_addr;

   int errors = 0;
   int checks = 0;
   logic [31:0] wb_log [16];
   int          wb_n;
   logic        last_more;

   always #(CLK_PERIOD/2) clk = ~clk;

   cme_engine u_cme_engine (
      .clk (clk), .rst_n (rst_n),
      .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_scope (cmd_scope),
      .cmd_operand (cmd_operand), .busy (busy), .done (done),
      .done_more (done_more), .ins_valid (ins_valid), .ins_ready (ins_ready),
      .ins_addr (ins_addr), .ins_way (ins_way), .ins_dirty (ins_dirty),
      .lk_addr (lk_addr), .lk_hit (lk_hit), .lk_dirty (lk_dirty),
      .wb_valid (wb_valid), .wb_ready (wb_ready), .wb_addr (wb_addr)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  sc;
      logic [31:0] opnd;
      logic [3:0]  nwb;
      logic [31:0] waddr;
      logic        more;
   } row_t;

   // line A tag11 set1 way0 dirty, B tag22 set1 way2 clean,
   // C tag33 set5 way3 dirty, D tag44 set0 way1 dirty, E tag55 set7 way3 dirty
   localparam row_t TBL [7] = '{
      '{2'd3, 2'd0, 32'h0000_0000, 4'd1, 32'h0000_1120, 1'b1},
      '{2'd3, 2'd0, 32'h0000_0000, 4'd1, 32'h0000_4400, 1'b1},
      '{2'd1, 2'd1, 32'h0000_223F, 4'd0, 32'h0000_0000, 1'b1},
      '{2'd2, 2'd2, 32'hC000_00A0, 4'd1, 32'h0000_33A0, 1'b1},
      '{2'd1, 2'd1, 32'h0000_99A7, 4'd0, 32'h0000_0000, 1'b1},
      '{2'd0, 2'd1, 32'h0000_55FF, 4'd0, 32'h0000_0000, 1'b0},
      '{2'd3, 2'd0, 32'h0000_0000, 4'd0, 32'h0000_0000, 1'b0}
   };
   string row_req [7] = '{"R6", "R6", "R7", "R4", "R8", "R7", "R6"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic install(input logic [23:0] tag, input logic [2:0] set,
                          input logic [1:0] way, input logic dirty);
      @(negedge clk);
      ins_valid = 1'b1;
      ins_addr  = {tag, set, 5'b0};
      ins_way   = way;
      ins_dirty = dirty;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic start_cmd(input logic [1:0] op, input logic [1:0] sc, input logic [31:0] opnd);
      @(negedge clk);
      cmd_valid   = 1'b1;
      cmd_op      = op;
      cmd_scope   = sc;
      cmd_operand = opnd;
      wb_n        = 0;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (1) begin
         if (wb_valid && wb_ready) begin
            if (wb_n < 16) wb_log[wb_n] = wb_addr;
            wb_n++;
         end
         if (done) begin
            last_more = done_more;
            break;
         end
         @(negedge clk);
         guard++;
         if (guard > 2000) begin
            errors++;
            $display("FAIL R9 command never completed actual=busy expected=done");
            break;
         end
      end
      @(negedge clk);
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [1:0] sc, input logic [31:0] opnd);
      start_cmd(op, sc, opnd);
      wait_done();
   endtask

   task automatic look(input string req, input logic [31:0] a, input logic hit, input logic dirty);
      @(negedge clk);
      lk_addr = a;
      #1;
      check(req, {30'b0, lk_hit, lk_dirty}, {30'b0, hit, dirty});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      check("R11 busy", {31'b0, busy}, 32'd0);
      check("R11 done", {31'b0, done}, 32'd0);
      check("R11 wb_valid", {31'b0, wb_valid}, 32'd0);
      check("R11 ins_ready", {31'b0, ins_ready}, 32'd1);
      look("R11 no valid line", 32'h0000_1120, 1'b0, 1'b0);

      install(24'h11, 3'd1, 2'd0, 1'b1);
      install(24'h22, 3'd1, 2'd2, 1'b0);
      install(24'h33, 3'd5, 2'd3, 1'b1);
      install(24'h44, 3'd0, 2'd1, 1'b1);
      install(24'h55, 3'd7, 2'd3, 1'b1);

      for (int r = 0; r < 7; r++) begin
         run_cmd(TBL[r].op, TBL[r].sc, TBL[r].opnd);
         check($sformatf("%s row %0d wb count", row_req[r], r), wb_n, {28'b0, TBL[r].nwb});
         if (TBL[r].nwb != 0)
            check($sformatf("%s row %0d wb addr", row_req[r], r), wb_log[0], TBL[r].waddr);
         check($sformatf("R12 row %0d more", r), {31'b0, last_more}, {31'b0, TBL[r].more});
      end

      look("R1 cleaned line stays valid", 32'h0000_1120, 1'b1, 1'b0);
      look("R3 clean-invalidated line gone", 32'h0000_33A0, 1'b0, 1'b0);
      look("R2 invalidated line gone", 32'h0000_55E0, 1'b0, 1'b0);
      look("R7 lookup ignores offset", 32'h0000_223F, 1'b1, 1'b0);

      // R2 whole invalidate: one cycle, no traffic
      install(24'h77, 3'd3, 2'd1, 1'b1);
      start_cmd(2'd0, 2'd0, 32'h0);
      check("R2 whole invalidate done next cycle", {31'b0, done}, 32'd1);
      wait_done();
      check("R2 whole invalidate traffic", wb_n, 32'd0);
      look("R2 dirty line dropped", 32'h0000_7760, 1'b0, 1'b0);
      look("R2 clean line dropped", 32'h0000_1120, 1'b0, 1'b0);

      // R5 walk order: sets inner, ways outer
      install(24'h61, 3'd2, 2'd0, 1'b1);
      install(24'h62, 3'd0, 2'd1, 1'b1);
      install(24'h63, 3'd7, 2'd0, 1'b1);
      install(24'h64, 3'd3, 2'd3, 1'b1);
      install(24'h65, 3'd4, 2'd2, 1'b0);
      run_cmd(2'd1, 2'd0, 32'h0);
      check("R5 walk wb count", wb_n, 32'd4);
      check("R5 walk first", wb_log[0], 32'h0000_6140);
      check("R5 walk second", wb_log[1], 32'h0000_63E0);
      check("R5 walk third", wb_log[2], 32'h0000_6200);
      check("R5 walk fourth", wb_log[3], 32'h0000_6460);
      check("R12 more after whole clean", {31'b0, last_more}, 32'd0);
      look("R1 whole clean keeps valid", 32'h0000_6200, 1'b1, 1'b0);

      // R10 / R9 back-pressure during whole clean-and-invalidate
      install(24'h66, 3'd6, 2'd1, 1'b1);
      wb_ready = 1'b0;
      start_cmd(2'd2, 2'd0, 32'h0);
      repeat (16) @(negedge clk);
      check("R10 stalled wb_valid", {31'b0, wb_valid}, 32'd1);
      check("R10 stalled addr", wb_addr, 32'h0000_66C0);
      check("R9 busy during stall", {31'b0, busy}, 32'd1);
      check("R9 installs refused", {31'b0, ins_ready}, 32'd0);
      repeat (3) @(negedge clk);
      check("R10 addr held", wb_addr, 32'h0000_66C0);
      wb_ready = 1'b1;
      wait_done();
      check("R3 single wb on release", wb_n, 32'd1);
      check("R9 idle after done", {31'b0, busy}, 32'd0);
      look("R3 dirty line invalid", 32'h0000_66C0, 1'b0, 1'b0);
      look("R3 clean line invalid", 32'h0000_6580, 1'b0, 1'b0);

      // R4 reserved scope changes nothing
      install(24'h70, 3'd4, 2'd1, 1'b1);
      run_cmd(2'd2, 2'd3, 32'h0000_7080);
      check("R4 reserved scope traffic", wb_n, 32'd0);
      check("R12 reserved scope more", {31'b0, last_more}, 32'd1);
      look("R4 line untouched", 32'h0000_7080, 1'b1, 1'b1);

      // R8 address miss on otherwise dirty set
      run_cmd(2'd2, 2'd1, 32'h0000_7180);
      check("R8 miss traffic", wb_n, 32'd0);
      look("R8 line untouched", 32'h0000_7080, 1'b1, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule